// File: doc/BRIEF.md
# Associative Page Translator with Two-Phase Row/Column Address Drive

This block turns a 27-bit logical word address into a physical RAM location. The upper 15 bits form a logical page number. That number is searched in parallel across a small table of page entries. The matching entry supplies two things: a chip-select code that picks one of four row groups, and three extra column bits that pick a 4K-word block inside the row. The lower 12 bits are the word offset inside that block, and they pass through unchanged.

The result is a 15-bit physical address: an 8-bit row part (X) and a 7-bit column part (Y). It leaves the block over an 8-line bus in two phases, each marked by its own strobe. The top bit of Y chooses between the even bank and the odd bank of rows. The block therefore drives one of eight row-select lines, and it holds that line for the whole access.

Page entries are loaded through a one-clock write port. A lookup that finds no valid entry raises a miss pulse and issues nothing else.

Top module: `page_mapper`

## Requirements
- R1: While reset is asserted, and after it is released, all outputs are low and every table entry is invalid. A lookup made straight after reset therefore misses.
- R2: A write loads an entry (index, 15-bit tag, 2-bit select code, 3-bit column extension, valid bit) in one clock. A lookup of that tag issued afterwards uses the new contents.
- R3: A request is taken in the idle state. `hit_o` or `miss_o` pulses high for exactly one cycle, two clock edges after the request edge. The two are never high together, and `hit_o` is high together with `xstb_o`.
- R4: On a miss, no row select and no strobe are asserted, and the sequencer goes back to idle.
- R5: At most one of `row_sel_o` is high. On a hit it is bit 2*cs + ymsb, where cs is the entry's select code and ymsb is bit 2 of its column extension. Even positions are even rows and odd positions are odd rows.
- R6: In the cycle with `xstb_o`, the bus carries logical address bits [7:0]. In the next cycle, with `ystb_o`, it carries {0, ext[2:0], addr[11:8]}, so its top line is low. `done_o` pulses in the cycle after that.
- R7: The chosen row select is held from the X phase through the done cycle and is low at all other times.
- R8: When several valid entries match, the one with the lowest index wins.
- R9: An entry whose valid bit is 0 never matches.
- R10: A request made while a sequence is in progress is ignored. The running sequence completes unchanged, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Translation request, taken in idle |
| laddr_i | input | 27 | Logical address: page number [26:12], offset [11:0] |
| wr_en_i | input | 1 | Table write enable |
| wr_idx_i | input | 4 | Entry index to write |
| wr_tag_i | input | 15 | Page number stored in the entry |
| wr_cs_i | input | 2 | Row-group select code |
| wr_yext_i | input | 3 | Column extension bits |
| wr_valid_i | input | 1 | Valid bit stored in the entry |
| row_sel_o | output | 8 | One-hot row select (even rows on even bits) |
| abus_o | output | 8 | Multiplexed address bus |
| xstb_o | output | 1 | X-phase strobe |
| ystb_o | output | 1 | Y-phase strobe |
| hit_o | output | 1 | Lookup hit pulse |
| miss_o | output | 1 | Lookup miss pulse |
| done_o | output | 1 | Access-complete pulse |

## Verification
The properties place no constraint on `req_i` or on the write port, because the sequencer alone orders the strobes and holds the row select. They do assume one thing: the table contents do not change between a lookup and the phases that follow it. The stimulus makes table writes only while the sequencer is idle, so the bench's own copy of the table always matches what the lookup sees. Extra requests are driven only during an access, so that they test the ignore rule.

// File: rtl/pm_pkg.sv
package pm_pkg;
  parameter int TAG_W  = 15;
  parameter int OFS_W  = 12;
  parameter int YEXT_W = 3;
  parameter int CS_W   = 2;
  parameter int X_W    = 8;
  parameter int BUS_W  = 8;
  localparam int LA_W  = TAG_W + OFS_W;
  localparam int Y_W   = OFS_W + YEXT_W - X_W;
  localparam int ROWS  = 2 * (1 << CS_W);

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [CS_W-1:0]   cs;
    logic [YEXT_W-1:0] yext;
  } cam_ent_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOOK = 3'd1,
    S_XPH  = 3'd2,
    S_YPH  = 3'd3,
    S_DONE = 3'd4
  } seq_st_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pm_cam.sv
module pm_cam
  import pm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cam_ent_t         wr_ent,
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output cam_ent_t         hit_ent
);
  cam_ent_t           ents [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic ld_en;
    assign ld_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ents[g] <= '0;
      else if (ld_en) ents[g] <= wr_ent;
    end

    assign match[g] = ents[g].valid && (ents[g].tag == key);
  end

  // lowest index wins: scan downward so the last assignment is the lowest match
  always_comb begin
    hit_ent = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_ent = ents[i];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LA_W-1:0]   laddr,
  input  logic              cam_hit,
  input  cam_ent_t          cam_ent,
  output logic [TAG_W-1:0]  key,
  output logic [ROWS-1:0]   row_sel,
  output logic [BUS_W-1:0]  abus,
  output logic              xstb,
  output logic              ystb,
  output logic              hit,
  output logic              miss,
  output logic              done
);
  seq_st_t           st_q, st_d;
  logic [LA_W-1:0]   addr_q;
  logic              addr_en;
  logic [YEXT_W-1:0] yext_q;
  logic              yext_en;
  logic [ROWS-1:0]   row_q, row_d;
  logic [BUS_W-1:0]  abus_q, abus_d;
  logic              xstb_q, xstb_d, ystb_q, ystb_d;
  logic              hit_q, hit_d, miss_q, miss_d, done_q, done_d;
  logic [Y_W-1:0]    yaddr;

  assign yaddr = {yext_q, addr_q[OFS_W-1:X_W]};

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    yext_en = 1'b0;
    row_d   = row_q;
    abus_d  = '0;
    xstb_d  = 1'b0;
    ystb_d  = 1'b0;
    hit_d   = 1'b0;
    miss_d  = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        row_d = '0;
        if (req) begin
          addr_en = 1'b1;
          st_d    = S_LOOK;
        end
      end
      S_LOOK: begin
        if (cam_hit) begin
          st_d    = S_XPH;
          yext_en = 1'b1;
          hit_d   = 1'b1;
          xstb_d  = 1'b1;
          abus_d  = BUS_W'(addr_q[X_W-1:0]);
          row_d   = '0;
          row_d[{cam_ent.cs, cam_ent.yext[YEXT_W-1]}] = 1'b1;
        end else begin
          miss_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      S_XPH: begin
        st_d   = S_YPH;
        ystb_d = 1'b1;
        abus_d = BUS_W'(yaddr);
      end
      S_YPH: begin
        st_d   = S_DONE;
        done_d = 1'b1;
      end
      S_DONE: begin
        st_d  = S_IDLE;
        row_d = '0;
      end
      default: begin
        st_d  = S_IDLE;
        row_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      yext_q <= '0;
      row_q  <= '0;
      abus_q <= '0;
      xstb_q <= 1'b0;
      ystb_q <= 1'b0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (addr_en) addr_q <= laddr;
      if (yext_en) yext_q <= cam_ent.yext;
      row_q  <= row_d;
      abus_q <= abus_d;
      xstb_q <= xstb_d;
      ystb_q <= ystb_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
      done_q <= done_d;
    end
  end

  assign key     = addr_q[LA_W-1:OFS_W];
  assign row_sel = row_q;
  assign abus    = abus_q;
  assign xstb    = xstb_q;
  assign ystb    = ystb_q;
  assign hit     = hit_q;
  assign miss    = miss_q;
  assign done    = done_q;
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [LA_W-1:0]   laddr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [CS_W-1:0]   wr_cs_i,
  input  logic [YEXT_W-1:0] wr_yext_i,
  input  logic              wr_valid_i,
  output logic [ROWS-1:0]   row_sel_o,
  output logic [BUS_W-1:0]  abus_o,
  output logic              xstb_o,
  output logic              ystb_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              done_o
);
  logic             rst_n_sync;
  cam_ent_t         wr_ent;
  cam_ent_t         hit_ent;
  logic             cam_hit;
  logic [TAG_W-1:0] key;

  assign wr_ent = '{valid: wr_valid_i, tag: wr_tag_i, cs: wr_cs_i, yext: wr_yext_i};

  pm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pm_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en_i),
    .wr_idx  (wr_idx_i),
    .wr_ent  (wr_ent),
    .key     (key),
    .hit     (cam_hit),
    .hit_ent (hit_ent)
  );

  pm_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .req     (req_i),
    .laddr   (laddr_i),
    .cam_hit (cam_hit),
    .cam_ent (hit_ent),
    .key     (key),
    .row_sel (row_sel_o),
    .abus    (abus_o),
    .xstb    (xstb_o),
    .ystb    (ystb_o),
    .hit     (hit_o),
    .miss    (miss_o),
    .done    (done_o)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker
  import pm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [ROWS-1:0]  row_sel,
  input logic [BUS_W-1:0] abus,
  input logic             xstb,
  input logic             ystb,
  input logic             hit,
  input logic             miss,
  input logic             done
);
  a_r5_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  a_r3_hit_with_xstb: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> xstb);

  a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (row_sel == '0) && !xstb && !ystb && !done);

  a_r6_x_then_y: assert property (@(posedge clk) disable iff (!rst_n)
    xstb |=> ystb);

  a_r6_y_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    ystb |=> done);

  a_r6_y_top_low: assert property (@(posedge clk) disable iff (!rst_n)
    ystb |-> !abus[BUS_W-1]);

  a_r7_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ystb || done) |-> (row_sel != '0) && $stable(row_sel));

  a_r7_row_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!xstb && !ystb && !done) |-> (row_sel == '0));
endmodule

bind page_mapper pm_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .row_sel (row_sel_o),
  .abus    (abus_o),
  .xstb    (xstb_o),
  .ystb    (ystb_o),
  .hit     (hit_o),
  .miss    (miss_o),
  .done    (done_o)
);

// File: tb/page_mapper_tb_top.sv
module page_mapper_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [26:0] laddr_i;
  logic        wr_en_i;
  logic [3:0]  wr_idx_i;
  logic [14:0] wr_tag_i;
  logic [1:0]  wr_cs_i;
  logic [2:0]  wr_yext_i;
  logic        wr_valid_i;
  logic [7:0]  row_sel_o;
  logic [7:0]  abus_o;
  logic        xstb_o, ystb_o, hit_o, miss_o, done_o;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  logic [14:0] m_tag   [16];
  logic [1:0]  m_cs    [16];
  logic [2:0]  m_yext  [16];
  logic        m_valid [16];

  page_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .laddr_i(laddr_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i),
    .wr_cs_i(wr_cs_i), .wr_yext_i(wr_yext_i), .wr_valid_i(wr_valid_i),
    .row_sel_o(row_sel_o), .abus_o(abus_o), .xstb_o(xstb_o), .ystb_o(ystb_o),
    .hit_o(hit_o), .miss_o(miss_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      finish_run();
    end
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic write_ent(int idx, logic [14:0] tag, logic [1:0] cs,
                           logic [2:0] yx, logic v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_tag_i = tag;
    wr_cs_i = cs; wr_yext_i = yx; wr_valid_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
    m_tag[idx] = tag; m_cs[idx] = cs; m_yext[idx] = yx; m_valid[idx] = v;
  endtask

  task automatic lookup(logic [14:0] tag, logic [11:0] off, bit busy_req);
    int hit_i = -1;
    logic [7:0] exp_row;
    for (int i = 15; i >= 0; i--)
      if (m_valid[i] && m_tag[i] == tag) hit_i = i;
    @(negedge clk);
    req_i = 1'b1; laddr_i = {tag, off};
    @(negedge clk);
    req_i = 1'b0;
    check("R3 no early result", {hit_o, miss_o, xstb_o}, 3'b000);
    @(negedge clk);
    if (hit_i >= 0) begin
      exp_row = 8'h01 << (m_cs[hit_i] * 2 + int'(m_yext[hit_i][2]));
      check("R3 hit pulse", {hit_o, miss_o}, 2'b10);
      check("R6 xstb", {xstb_o, ystb_o}, 2'b10);
      check("R6 x address", abus_o, off[7:0]);
      check("R5/R8 row select", row_sel_o, exp_row);
      if (busy_req) begin
        req_i = 1'b1; laddr_i = ~{tag, off};
      end
      @(negedge clk);
      check("R3 single hit pulse", hit_o, 1'b0);
      check("R6 ystb", {xstb_o, ystb_o}, 2'b01);
      check("R6 y address", abus_o, {1'b0, m_yext[hit_i], off[11:8]});
      check("R7 row held y", row_sel_o, exp_row);
      @(negedge clk);
      check("R6 done", {ystb_o, done_o}, 2'b01);
      check("R7 row held done", row_sel_o, exp_row);
      req_i = 1'b0;
      @(negedge clk);
      check("R7 row released", {row_sel_o, done_o}, 9'd0);
      if (busy_req) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R10 no second sequence", {hit_o, miss_o, xstb_o, row_sel_o}, 11'd0);
        end
      end
    end else begin
      check("R3/R4 miss pulse", {hit_o, miss_o}, 2'b01);
      check("R4 miss quiet", {row_sel_o, xstb_o, ystb_o, done_o}, 11'd0);
      @(negedge clk);
      check("R4 back to idle", {miss_o, row_sel_o, xstb_o, ystb_o}, 11'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; laddr_i = '0; wr_en_i = 1'b0;
    wr_idx_i = '0; wr_tag_i = '0; wr_cs_i = '0; wr_yext_i = '0; wr_valid_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = '0; m_cs[i] = '0; m_yext[i] = '0; m_valid[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R1 outputs in reset",
          {row_sel_o, abus_o, xstb_o, ystb_o, hit_o, miss_o, done_o}, 21'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs after reset",
          {row_sel_o, abus_o, xstb_o, ystb_o, hit_o, miss_o, done_o}, 21'd0);
    // R1: empty table misses, even for tag 0
    lookup(15'h0000, 12'h000, 1'b0);
    lookup(15'h7FFF, 12'hABC, 1'b0);

    // R2, R5, R6: sweep all entries, every select code and extension
    for (int i = 0; i < 16; i++)
      write_ent(i, 15'(15'h0100 + i * 15'd37), 2'(i % 4), 3'((i * 3) % 8), 1'b1);
    for (int i = 0; i < 16; i++) begin
      lookup(m_tag[i], 12'h000, 1'b0);
      lookup(m_tag[i], 12'hFFF, 1'b0);
      lookup(m_tag[i], 12'(i * 273 + 5), 1'b0);
    end
    // R1/R4: unknown page misses
    lookup(15'h7ABC, 12'h123, 1'b0);

    // R8: duplicate tag, lowest index wins
    write_ent(9, m_tag[3], 2'd2, 3'd5, 1'b1);
    lookup(m_tag[3], 12'h5A5, 1'b0);
    // R9: invalidate the lower entry, the higher one now answers
    write_ent(3, m_tag[3], 2'd0, 3'd0, 1'b0);
    lookup(m_tag[9], 12'h5A5, 1'b0);
    // R9: invalidate the last one, page now misses
    write_ent(9, m_tag[9], 2'd1, 3'd1, 1'b0);
    lookup(m_tag[9], 12'h5A5, 1'b0);
    // R2: rewrite an entry and see new contents
    write_ent(5, 15'h2222, 2'd3, 3'd7, 1'b1);
    lookup(15'h2222, 12'h0F0, 1'b0);

    // R10: requests during a running sequence are ignored
    lookup(m_tag[6], 12'h321, 1'b1);
    lookup(15'h2222, 12'hE01, 1'b1);

    finish_run();
  end
endmodule